// File: doc/BRIEF.md
# Laserdisc Player Port Bridge

This block sits between an 8-bit memory-mapped CPU bus and the parallel data port of an external laserdisc player. It turns particular CPU addresses into strobes and enables for the player.

On the read side, a write of any value to an arming window does not transfer data. It only sets a read-enable flag, and that flag drives the player's active-low read enable. A later CPU read of the status address opens the path from the player's data lines onto the CPU read data. The end of that read clears the flag again, so the read enable seen by the player starts before the CPU read window and ends after it.

On the write side, a write to a latch address captures CPU data into an 8-bit register. A write to a separate drive address presents that register to the player for as long as the drive access lasts. The player's active-low write enable tracks that same drive strobe.

All bus inputs pass through one register stage, and every strobe is decoded from the registered copy. The arming set is modelled as a synchronous set that wins over the clear, so the whole block runs in one clock domain.

Top module: `ldb_port_bridge`

## Requirements
- R1: After reset, `rden_no` and `wren_no` are 1, `rd_oe_o` and `wr_oe_o` are 0, and `rdata_o` and `plr_data_o` are 0x00.
- R2: A write of any value to an address from 0x4218 to 0x421F drives `rden_no` low at the second rising edge after the access is presented. Writes to 0x4217 and to 0x4220 leave `rden_no` unchanged.
- R3: During a read of 0x4105, from the first edge after it is presented until the first edge after it is withdrawn:
  - `rd_oe_o` is 1;
  - `rdata_o` equals `plr_data_i`, following it combinationally.
- R4: The edge at which the 0x4105 read strobe falls is followed by a clear of the flag at the next edge, so `rden_no` returns high one cycle after `rd_oe_o` drops. This holds unless an arming write falls in the same cycle (see R6).
- R5: A 0x4105 read with no arming write beforehand leaves `rden_no` high throughout. Only an arming write sets the flag.
- R6: If an arming write is decoded in the same cycle as the end of a 0x4105 read, `rden_no` stays low.
- R7: A write to 0x4230 loads its data into the output register at the second edge after the access is presented.
  - A write to 0x4238 makes `wr_oe_o` 1 and `wren_no` 0 from the first edge after it is presented, for as long as it is held.
  - `plr_data_o` always shows the output register.
- R8: The data carried by a 0x4238 write is ignored, and `plr_data_o` keeps the latched value.
- R9: When no 0x4105 read is decoded, for example when the read is withdrawn or a read targets 0x4106, `rd_oe_o` is 0 and `rdata_o` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | CPU address |
| wdata_i | input | 8 | CPU write data |
| rd_i | input | 1 | CPU read access valid |
| wr_i | input | 1 | CPU write access valid |
| plr_data_i | input | 8 | Data lines from the player |
| rdata_o | output | 8 | CPU read data, 0 when the status read is not selected |
| rd_oe_o | output | 1 | Enable of the player-to-CPU buffer |
| plr_data_o | output | 8 | Output register toward the player |
| wr_oe_o | output | 1 | Enable of the CPU-to-player driver |
| rden_no | output | 1 | Read enable to the player, active low |
| wren_no | output | 1 | Write enable to the player, active low |

## Verification
The bench builds the block with its default parameters:
- a 16-bit address;
- an 8-entry arming window at 0x4218;
- the status read at 0x4105;
- latch and drive at 0x4230 and 0x4238.

With these values the bench can reach both edges of the arming window and a neighbouring read address. It can also end a read directly into an arming write, which places the clear and the set in one cycle. The bench also holds the drive access across several cycles with unrelated data on the bus.

// File: rtl/ldb_pkg.sv
package ldb_pkg;
  typedef struct packed {
    logic arm;
    logic rd;
    logic latch;
    logic drive;
  } strb_t;
endpackage

// File: rtl/ldb_bus_stage.sv
module ldb_bus_stage #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_i,
  input  logic              wr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              rd_o,
  output logic              wr_o,
  output logic              valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o  <= '0;
      wdata_o <= '0;
      rd_o    <= 1'b0;
      wr_o    <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      addr_o  <= addr_i;
      wdata_o <= wdata_i;
      rd_o    <= rd_i;
      wr_o    <= wr_i;
      valid_o <= rd_i | wr_i;
    end
  end
endmodule

// File: rtl/ldb_decode.sv
module ldb_decode
  import ldb_pkg::*;
#(
  parameter int              ADDR_W        = 16,
  parameter int              ARM_SPAN_LOG2 = 3,
  parameter logic [ADDR_W-1:0] ARM_BASE    = 16'h4218,
  parameter logic [ADDR_W-1:0] RD_ADDR     = 16'h4105,
  parameter logic [ADDR_W-1:0] LATCH_ADDR  = 16'h4230,
  parameter logic [ADDR_W-1:0] DRIVE_ADDR  = 16'h4238
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic              valid_i,
  output strb_t             strb_o
);
  logic in_arm;

  generate
    if (ARM_SPAN_LOG2 > 0) begin : g_window
      localparam int TAG_W = ADDR_W - ARM_SPAN_LOG2;
      localparam logic [TAG_W-1:0] ARM_TAG = ARM_BASE[ADDR_W-1:ARM_SPAN_LOG2];
      assign in_arm = (addr_i[ADDR_W-1:ARM_SPAN_LOG2] == ARM_TAG);
    end else begin : g_single
      assign in_arm = (addr_i == ARM_BASE);
    end
  endgenerate

  always_comb begin
    strb_o       = '0;
    strb_o.arm   = valid_i & wr_i & in_arm;
    strb_o.rd    = valid_i & rd_i & (addr_i == RD_ADDR);
    strb_o.latch = valid_i & wr_i & (addr_i == LATCH_ADDR);
    strb_o.drive = valid_i & wr_i & (addr_i == DRIVE_ADDR);
  end
endmodule

// File: rtl/ldb_read_path.sv
module ldb_read_path #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic              rd_sel_i,
  input  logic [DATA_W-1:0] plr_data_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rd_oe_o,
  output logic              rden_no
);
  logic flag_q;
  logic rd_sel_d;
  logic rd_end;

  // read strobe trailing edge clocks a constant 0 into the flag
  assign rd_end = rd_sel_d & ~rd_sel_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q   <= 1'b0;
      rd_sel_d <= 1'b0;
    end else begin
      rd_sel_d <= rd_sel_i;
      if (arm_i)       flag_q <= 1'b1;
      else if (rd_end) flag_q <= 1'b0;
    end
  end

  assign rd_oe_o = rd_sel_i;
  assign rdata_o = rd_sel_i ? plr_data_i : '0;
  assign rden_no = ~flag_q;
endmodule

// File: rtl/ldb_write_path.sv
module ldb_write_path #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              latch_i,
  input  logic              drive_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] plr_data_o,
  output logic              wr_oe_o,
  output logic              wren_no
);
  logic [DATA_W-1:0] out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      out_q <= '0;
    else if (latch_i) out_q <= wdata_i;
  end

  assign plr_data_o = out_q;
  assign wr_oe_o    = drive_i;
  assign wren_no    = ~drive_i;
endmodule

// File: rtl/ldb_port_bridge.sv
module ldb_port_bridge
  import ldb_pkg::*;
#(
  parameter int              ADDR_W        = 16,
  parameter int              DATA_W        = 8,
  parameter int              ARM_SPAN_LOG2 = 3,
  parameter logic [ADDR_W-1:0] ARM_BASE    = 16'h4218,
  parameter logic [ADDR_W-1:0] RD_ADDR     = 16'h4105,
  parameter logic [ADDR_W-1:0] LATCH_ADDR  = 16'h4230,
  parameter logic [ADDR_W-1:0] DRIVE_ADDR  = 16'h4238
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] plr_data_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rd_oe_o,
  output logic [DATA_W-1:0] plr_data_o,
  output logic              wr_oe_o,
  output logic              rden_no,
  output logic              wren_no
);
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              rd_q, wr_q, valid_q;
  strb_t             strb;
  logic              arm_stb;

  ldb_bus_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rd_i    (rd_i),
    .wr_i    (wr_i),
    .addr_o  (addr_q),
    .wdata_o (wdata_q),
    .rd_o    (rd_q),
    .wr_o    (wr_q),
    .valid_o (valid_q)
  );

  ldb_decode #(
    .ADDR_W(ADDR_W), .ARM_SPAN_LOG2(ARM_SPAN_LOG2), .ARM_BASE(ARM_BASE),
    .RD_ADDR(RD_ADDR), .LATCH_ADDR(LATCH_ADDR), .DRIVE_ADDR(DRIVE_ADDR)
  ) u_dec (
    .addr_i  (addr_q),
    .rd_i    (rd_q),
    .wr_i    (wr_q),
    .valid_i (valid_q),
    .strb_o  (strb)
  );

  assign arm_stb = strb.arm;

  ldb_read_path #(.DATA_W(DATA_W)) u_rd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .arm_i      (strb.arm),
    .rd_sel_i   (strb.rd),
    .plr_data_i (plr_data_i),
    .rdata_o    (rdata_o),
    .rd_oe_o    (rd_oe_o),
    .rden_no    (rden_no)
  );

  ldb_write_path #(.DATA_W(DATA_W)) u_wr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .latch_i    (strb.latch),
    .drive_i    (strb.drive),
    .wdata_i    (wdata_q),
    .plr_data_o (plr_data_o),
    .wr_oe_o    (wr_oe_o),
    .wren_no    (wren_no)
  );
endmodule

// File: rtl/ldb_checker.sv
module ldb_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              arm_stb,
  input logic              rd_oe_o,
  input logic              wr_oe_o,
  input logic              rden_no,
  input logic [DATA_W-1:0] plr_data_o
);
  p_arm_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_stb |=> !rden_no);

  p_read_end_clears_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(rd_oe_o) && !arm_stb) |=> rden_no);

  p_only_arm_sets_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rden_no && !arm_stb) |=> rden_no);

  p_set_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(rd_oe_o) && arm_stb) |=> !rden_no);

  p_drive_holds_data_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_oe_o && $past(wr_oe_o)) |-> $stable(plr_data_o));
endmodule

bind ldb_port_bridge ldb_checker #(.DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .arm_stb    (arm_stb),
  .rd_oe_o    (rd_oe_o),
  .wr_oe_o    (wr_oe_o),
  .rden_no    (rden_no),
  .plr_data_o (plr_data_o)
);

// File: tb/tb_ldb_port_bridge.sv
`timescale 1ns/1ps
module tb_ldb_port_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        rd = 1'b0, wr = 1'b0;
  logic [7:0]  plr = '0;
  logic [7:0]  rdata, pdata;
  logic        rd_oe, wr_oe, rden_n, wren_n;

  int total = 0, bad = 0, ncyc = 0;
  bit done = 0;

  typedef struct {
    int       cyc;
    string    req;
    logic     rden, wren, rdoe, wroe;
    logic [7:0] rdat, pdat;
  } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  ldb_port_bridge dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .rd_i(rd), .wr_i(wr), .plr_data_i(plr), .rdata_o(rdata),
    .rd_oe_o(rd_oe), .plr_data_o(pdata), .wr_oe_o(wr_oe),
    .rden_no(rden_n), .wren_no(wren_n)
  );

  always @(posedge clk) ncyc++;

  // monitor: compare items due this cycle
  always @(negedge clk) begin
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].cyc == ncyc) begin
        logic [19:0] act, expv;
        act  = {rden_n, wren_n, rd_oe, wr_oe, rdata, pdata};
        expv = {q[i].rden, q[i].wren, q[i].rdoe, q[i].wroe, q[i].rdat, q[i].pdat};
        total++;
        if (act !== expv) begin
          bad++;
          $display("FAIL %s cyc=%0d actual=%05h expected=%05h", q[i].req, ncyc, act, expv);
        end
        q.delete(i);
      end
    end
  end

  task automatic expect_at(int ahead, string req, logic rden, logic wren,
                           logic rdoe, logic wroe, logic [7:0] rdat, logic [7:0] pdat);
    exp_t e;
    e.cyc = ncyc + ahead; e.req = req;
    e.rden = rden; e.wren = wren; e.rdoe = rdoe; e.wroe = wroe;
    e.rdat = rdat; e.pdat = pdat;
    q.push_back(e);
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic bus(logic r, logic w, logic [15:0] a, logic [7:0] d);
    rd = r; wr = w; addr = a; wdata = d;
  endtask

  task automatic idle();
    rd = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog run R1 actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    expect_at(1, "R1", 1, 1, 0, 0, 8'h00, 8'h00); step();

    // R5 / R3: unarmed read
    plr = 8'h3C; bus(1, 0, 16'h4105, 8'h00);
    expect_at(1, "R3", 1, 1, 1, 0, 8'h3C, 8'h00); step();
    plr = 8'hC3;
    expect_at(1, "R3", 1, 1, 1, 0, 8'hC3, 8'h00); step();
    idle();
    expect_at(1, "R9", 1, 1, 0, 0, 8'h00, 8'h00);
    expect_at(2, "R5", 1, 1, 0, 0, 8'h00, 8'h00); step(); step();

    // R9: neighbouring read address
    bus(1, 0, 16'h4106, 8'h00);
    expect_at(1, "R9", 1, 1, 0, 0, 8'h00, 8'h00); step(); idle(); step();

    // R2: window boundaries outside
    bus(0, 1, 16'h4217, 8'hAA);
    expect_at(2, "R2", 1, 1, 0, 0, 8'h00, 8'h00); step();
    bus(0, 1, 16'h4220, 8'hAA);
    expect_at(2, "R2", 1, 1, 0, 0, 8'h00, 8'h00); step();
    idle(); step(); step();

    // R2: arm
    bus(0, 1, 16'h421A, 8'h55);
    expect_at(1, "R2", 1, 1, 0, 0, 8'h00, 8'h00);
    expect_at(2, "R2", 0, 1, 0, 0, 8'h00, 8'h00); step(); idle(); step();

    // R3 / R4: armed read brackets the window
    plr = 8'h9E; bus(1, 0, 16'h4105, 8'h00);
    expect_at(1, "R3", 0, 1, 1, 0, 8'h9E, 8'h00); step();
    idle();
    expect_at(1, "R4", 0, 1, 0, 0, 8'h00, 8'h00);
    expect_at(2, "R4", 1, 1, 0, 0, 8'h00, 8'h00); step(); step();

    // R6: read ends straight into an arming write
    bus(0, 1, 16'h421F, 8'h00); step();
    bus(1, 0, 16'h4105, 8'h00);
    expect_at(1, "R2", 0, 1, 1, 0, 8'h9E, 8'h00); step();
    bus(0, 1, 16'h4218, 8'h00);
    expect_at(1, "R6", 0, 1, 0, 0, 8'h00, 8'h00);
    expect_at(2, "R6", 0, 1, 0, 0, 8'h00, 8'h00); step();
    idle(); step();
    expect_at(1, "R6", 0, 1, 0, 0, 8'h00, 8'h00); step();
    bus(1, 0, 16'h4105, 8'h00); step();
    idle();
    expect_at(2, "R4", 1, 1, 0, 0, 8'h00, 8'h00); step(); step();

    // R7 / R8: write path
    bus(0, 1, 16'h4230, 8'h6B);
    expect_at(1, "R7", 1, 1, 0, 0, 8'h00, 8'h00);
    expect_at(2, "R7", 1, 1, 0, 0, 8'h00, 8'h6B); step(); idle(); step();
    bus(0, 1, 16'h4238, 8'hFF);
    expect_at(1, "R7", 1, 0, 0, 1, 8'h00, 8'h6B); step();
    wdata = 8'h11;
    expect_at(1, "R8", 1, 0, 0, 1, 8'h00, 8'h6B); step();
    idle();
    expect_at(1, "R7", 1, 1, 0, 0, 8'h00, 8'h6B);
    expect_at(2, "R8", 1, 1, 0, 0, 8'h00, 8'h6B); step(); step();
    step();

    if (q.size() != 0) begin
      total++; bad++;
      $display("FAIL R1 pending checks actual=%0d expected=0", q.size());
    end
    done = 1;
    summary();
  end
endmodule